// File: doc/BRIEF.md
# Timer with Capture/Compare Channels

This block is a 16-bit timer core. A clock prescaler divides the system clock by 1, 2, 4 or 8 and produces a count enable. The counter runs in one of four modes. In stop mode it holds its value. In up mode it counts to the period value held in channel 0 and then returns to zero. In continuous mode it runs through the full 16-bit range. In up/down mode it climbs to the channel 0 value and then falls back to zero. Whenever the count returns to zero at the end of a cycle, the block raises an overflow flag.

Each capture/compare channel works in one of two ways. In capture mode, a chosen edge of the channel's input copies the running count into the channel register. The input can be passed through a two-stage synchroniser or used directly. In compare mode, the channel watches for the count to equal its register. On a match it raises its flag, sets a simple output and samples its input into a readable bit. Software reaches everything through a small word-addressed register port. Reading a channel's data word acknowledges the last capture, so that a capture that overwrites unread data can be flagged.

Top module: `cct_top`

## Requirements
- R1: After reset every readable word, the counter, the overflow flag, all channel flags and all channel outputs are zero.
- R2: Control word bits [1:0] select the prescale divide as 1, 2, 4 or 8 (codes 0 to 3). Writing 1 to control bit 4 zeroes the counter and the prescaler in the same cycle, and bit 4 always reads back 0.
- R3: Control bits [3:2] = 0 select stop mode, in which the counter holds its value. A write to word address 1 loads the counter.
- R4: Mode code 1 (up mode) counts from 0 up to the channel 0 register. On the next count the counter returns to 0, and on that same count the overflow flag and channel 0's compare flag set.
- R5: Mode code 2 (continuous mode) counts through the full 16-bit range. The wrap from 0xFFFF to 0 sets the overflow flag (control bit 5, also on pin `ovf_flag`).
- R6: Mode code 3 (up/down mode) counts 0 up to the channel 0 register and back down. The overflow flag sets on the count that reaches 0 while falling.
- R7: Channel control bit 0 = 1 selects capture mode. Bits [2:1] select the capture edge: 1 = rising, 2 = falling, 3 = both, 0 = none. A selected edge copies the count into the channel register and sets the channel flag (bit 4). An edge that is not selected changes neither of them.
- R8: Channel control bit 3 = 1 routes the capture input through a two-stage synchroniser, so a capture lands two clocks later than with bit 3 = 0. With divide by 1 the captured value is therefore larger by 2.
- R9: A capture that occurs while the previous capture is still unread sets the capture-overflow bit (bit 5). Reading the channel data word acknowledges the capture, and a later capture then leaves bit 5 clear.
- R10: In compare mode, while the counter is running, a count equal to the channel register sets the flag, sets the output (bit 7 and pin `ch_out`) and latches the channel input into bit 6. In stop mode no match is detected.
- R11: Word address 0 is the control word and address 1 is the counter. Channel i has its control word at address 2+2i and its data word at 2+2i+1. Software writes to the flag, capture-overflow and output bits overwrite them, unless a hardware event sets a bit in the same cycle, in which case the bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledges a channel data read) |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| cap_in | input | NUM_CH | Per-channel capture/compare input |
| ovf_flag | output | 1 | Counter overflow flag |
| ch_flag | output | NUM_CH | Per-channel capture/compare flag |
| ch_out | output | NUM_CH | Per-channel set-on-equal output |

## Verification
The bench times prescaler ticks at each divide setting, counting from the clear. A prescaler with an off-by-one phase would move every checked count by a tick. It drives the continuous-mode wrap from 0xFFFD, the return to zero in up mode and the turnaround in up/down mode, and checks that the overflow flag sets on exactly the cycle the count reaches zero. A design that flags at the peak, or one count late, fails here. For capture, the bench raises an asynchronous channel and a synchronised channel on the same edge and expects their captured values to differ by exactly two. It also checks that unselected edges leave the register alone and that the capture-overflow bit tracks read acknowledges. A compare match in stop mode must not set the flag.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CW = 16;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } cct_mode_e;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          down;
    logic          wrap;
  } cct_step_t;

  // Mask of prescaler bits that must all be 1 for a tick (divide by 2**div).
  function automatic logic [2:0] cct_div_mask(input logic [1:0] div);
    logic [3:0] m;
    m = (4'd1 << div) - 4'd1;
    return m[2:0];
  endfunction

  // One counting step: next count, next direction, and whether this step
  // lands on zero at the end of a cycle.
  function automatic cct_step_t cct_next(input logic [CW-1:0] cnt,
                                         input logic          down,
                                         input cct_mode_e     mode,
                                         input logic [CW-1:0] peak);
    cct_step_t s;
    s.cnt  = cnt;
    s.down = down;
    s.wrap = 1'b0;
    unique case (mode)
      MODE_STOP: ;
      MODE_UP: begin
        if (cnt >= peak) begin
          s.cnt  = '0;
          s.wrap = 1'b1;
        end else begin
          s.cnt = cnt + 1'b1;
        end
      end
      MODE_CONT: begin
        s.cnt  = cnt + 1'b1;
        s.wrap = (cnt == '1);
      end
      MODE_UPDN: begin
        if (!down && cnt < peak) begin
          s.cnt = cnt + 1'b1;
        end else if (cnt == '0) begin
          s.down = 1'b0;
        end else begin
          s.cnt  = cnt - 1'b1;
          s.down = (cnt != CW'(1));
          s.wrap = (cnt == CW'(1));
        end
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] div,
  output logic       tick
);
  logic [2:0] pcnt;
  logic [2:0] mask;

  assign mask = cct_div_mask(div);
  assign tick = ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else          pcnt <= pcnt + 3'd1;
  end

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != 2'd0 && !clr) |=> (!tick || div != $past(div))); // R2
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  cct_mode_e     mode,
  input  logic [CW-1:0] peak,
  input  logic          cnt_we,
  input  logic [CW-1:0] wdata,
  input  logic          ovf_we,
  input  logic          ovf_wdata,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          run,
  output logic          wrap_evt
);
  cct_step_t step;
  logic      down;

  assign step     = cct_next(cnt, down, mode, peak);
  assign run      = (mode != MODE_STOP);
  assign wrap_evt = tick && !clr && !cnt_we && step.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (cnt_we) begin
      cnt <= wdata;
    end else if (tick) begin
      cnt  <= step.cnt;
      down <= step.down;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (wrap_evt) ovf <= 1'b1;
    else if (ovf_we)   ovf <= ovf_wdata;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && !clr && !cnt_we) |=> $stable(cnt)); // R3
  AST_UP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UP && cnt >= peak && !clr && !cnt_we) |=> (cnt == '0 && ovf)); // R4
  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_CONT && cnt == '1 && !clr && !cnt_we) |=> (cnt == '0 && ovf)); // R5
  AST_UPDN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UPDN && down && cnt == CW'(1) && !clr && !cnt_we) |=> (cnt == '0 && ovf)); // R6
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          cap_in,
  input  logic          ctl_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ctl_rd,
  output logic [CW-1:0] ccr,
  output logic          flag,
  output logic          cout
);
  logic       cap_mode, sync_en, cov, scci, pending;
  logic [1:0] edge_sel;
  logic       s1, s2, prev_a, prev_s;
  logic       sel_in, sel_prev, rise, fall;
  logic       cap_evt, eq_evt;

  // Input conditioning: raw path and two-stage synchronised path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev_a <= 1'b0; prev_s <= 1'b0;
    end else begin
      s1 <= cap_in; s2 <= s1; prev_a <= cap_in; prev_s <= s2;
    end
  end

  assign sel_in   = sync_en ? s2 : cap_in;
  assign sel_prev = sync_en ? prev_s : prev_a;
  assign rise     = sel_in & ~sel_prev;
  assign fall     = ~sel_in & sel_prev;
  assign cap_evt  = cap_mode && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
  assign eq_evt   = !cap_mode && run && tick && (cnt == ccr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mode <= 1'b0; edge_sel <= '0; sync_en <= 1'b0;
      flag <= 1'b0; cov <= 1'b0; scci <= 1'b0; cout <= 1'b0;
      pending <= 1'b0; ccr <= '0;
    end else begin
      if (ctl_we) begin
        cap_mode <= wdata[0];
        edge_sel <= wdata[2:1];
        sync_en  <= wdata[3];
        flag     <= wdata[4];
        cov      <= wdata[5];
        cout     <= wdata[7];
      end
      if (data_we) ccr <= wdata;
      if (data_re) pending <= 1'b0;
      if (cap_evt) begin
        ccr     <= cnt;
        flag    <= 1'b1;
        pending <= 1'b1;
        if (pending && !data_re) cov <= 1'b1;
      end
      if (eq_evt) begin
        flag <= 1'b1;
        cout <= 1'b1;
        scci <= cap_in;
      end
    end
  end

  assign ctl_rd = {8'b0, cout, scci, cov, flag, sync_en, edge_sel, cap_mode};

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ccr == $past(cnt) && flag)); // R7
  AST_CAP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && pending && !data_re) |=> cov); // R9
  AST_EQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eq_evt |=> (flag && cout && scci == $past(cap_in))); // R10
endmodule

// File: rtl/cct_top.sv
module cct_top
  import cct_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  input  logic [NUM_CH-1:0] cap_in,
  output logic              ovf_flag,
  output logic [NUM_CH-1:0] ch_flag,
  output logic [NUM_CH-1:0] ch_out
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(1);

  logic          ctl_wr, clr, tick, run, wrap_evt;
  logic [1:0]    div_q;
  cct_mode_e     mode_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ch_ctl [NUM_CH];
  logic [CW-1:0] ch_ccr [NUM_CH];

  assign ctl_wr = wr_en && (addr == A_CTL);
  assign clr    = ctl_wr && wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= MODE_STOP;
    end else if (ctl_wr) begin
      div_q  <= wdata[1:0];
      mode_q <= cct_mode_e'(wdata[3:2]);
    end
  end

  cct_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .div(div_q), .tick(tick)
  );

  cct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .mode(mode_q),
    .peak(ch_ccr[0]), .cnt_we(wr_en && addr == A_CNT), .wdata(wdata),
    .ovf_we(ctl_wr), .ovf_wdata(wdata[5]), .cnt(cnt), .ovf(ovf_flag),
    .run(run), .wrap_evt(wrap_evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CCTL = ADDR_W'(2 + 2*i);
    localparam logic [ADDR_W-1:0] A_CDAT = ADDR_W'(3 + 2*i);
    cct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt(cnt),
      .cap_in(cap_in[i]),
      .ctl_we(wr_en && addr == A_CCTL),
      .data_we(wr_en && addr == A_CDAT),
      .data_re(rd_en && addr == A_CDAT),
      .wdata(wdata), .ctl_rd(ch_ctl[i]), .ccr(ch_ccr[i]),
      .flag(ch_flag[i]), .cout(ch_out[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTL) rdata = {10'b0, ovf_flag, 1'b0, mode_q, div_q};
    if (addr == A_CNT) rdata = cnt;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(2 + 2*i)) rdata = ch_ctl[i];
      if (addr == ADDR_W'(3 + 2*i)) rdata = ch_ccr[i];
    end
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag); // R11
  AST_CLR_RDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !rdata[4] || addr != A_CTL)); // R2
endmodule

// File: tb/tb_cct_top.sv
module tb_cct_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [2:0]  cap_in;
  logic        ovf_flag;
  logic [2:0]  ch_flag, ch_out;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cct_top #(.NUM_CH(3), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .ovf_flag(ovf_flag),
    .ch_flag(ch_flag), .ch_out(ch_out)
  );

  function automatic logic [15:0] ctlw(input logic [1:0] div, input logic [1:0] mode, input logic clr);
    return {11'b0, clr, mode, div};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic rd_ack(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1;
    v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(4'd0, v); chk("R1 ctl", v, 16'h0000);
    peek(4'd1, v); chk("R1 cnt", v, 16'h0000);
    peek(4'd4, v); chk("R1 ch1 ctl", v, 16'h0000);
    chk("R1 pins", {13'b0, ovf_flag, ch_flag | ch_out}, 16'h0000);
    wr(4'd7, 16'hBEEF);
    peek(4'd7, v); chk("R11 ch2 data addr", v, 16'hBEEF);
    peek(4'd5, v); chk("R11 ch1 data untouched", v, 16'h0000);
  endtask

  task automatic t_cont();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd2, 1'b1));
    peek(4'd1, v); chk("R2 clear", v, 16'h0000);
    peek(4'd0, v); chk("R2 clear bit reads 0", v, 16'h0008);
    wait_cyc(5);
    peek(4'd1, v); chk("R5 continuous count", v, 16'd5);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd2, 2'd2, 1'b1));
    wait_cyc(7);  peek(4'd1, v); chk("R2 div4 at 7", v, 16'd1);
    wait_cyc(5);  peek(4'd1, v); chk("R2 div4 at 12", v, 16'd3);
    wr(4'd0, ctlw(2'd3, 2'd2, 1'b1));
    wait_cyc(16); peek(4'd1, v); chk("R2 div8 at 16", v, 16'd2);
    wr(4'd0, ctlw(2'd1, 2'd2, 1'b1));
    wait_cyc(9);  peek(4'd1, v); chk("R2 div2 at 9", v, 16'd4);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd1, 16'hFFFD);
    wr(4'd0, ctlw(2'd0, 2'd2, 1'b0));
    peek(4'd1, v); chk("R3 counter load", v, 16'hFFFD);
    wait_cyc(2);
    peek(4'd1, v); chk("R5 before wrap", v, 16'hFFFF);
    chk("R5 no ovf yet", {15'b0, ovf_flag}, 16'h0000);
    wait_cyc(1);
    peek(4'd1, v); chk("R5 wrapped", v, 16'h0000);
    peek(4'd0, v); chk("R5 ovf bit", v, 16'h0028);
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    chk("R11 ovf cleared by write", {15'b0, ovf_flag}, 16'h0000);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd4, 16'h0000);
    wr(4'd5, 16'h1234);
    wr(4'd1, 16'h1234);
    wait_cyc(6);
    peek(4'd1, v); chk("R3 stop holds", v, 16'h1234);
    chk("R10 no match in stop", {15'b0, ch_flag[1]}, 16'h0000);
  endtask

  task automatic t_up();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'd4);
    wr(4'd0, ctlw(2'd0, 2'd1, 1'b1));
    wait_cyc(4);
    peek(4'd1, v); chk("R4 at peak", v, 16'd4);
    chk("R4 flags before return", {14'b0, ovf_flag, ch_flag[0]}, 16'h0000);
    wait_cyc(1);
    peek(4'd1, v); chk("R4 returned", v, 16'd0);
    chk("R4 ovf+ch0 flag+out", {13'b0, ovf_flag, ch_flag[0], ch_out[0]}, 16'h0007);
    wait_cyc(4);
    peek(4'd1, v); chk("R4 second period", v, 16'd4);
  endtask

  task automatic t_updn();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd3, 16'd3);
    wr(4'd0, ctlw(2'd0, 2'd3, 1'b1));
    wait_cyc(4);
    peek(4'd1, v); chk("R6 falling", v, 16'd2);
    wait_cyc(1);
    peek(4'd1, v); chk("R6 at one", v, 16'd1);
    chk("R6 no ovf at one", {15'b0, ovf_flag}, 16'h0000);
    wait_cyc(1);
    peek(4'd1, v); chk("R6 floor", v, 16'd0);
    chk("R6 ovf at floor", {15'b0, ovf_flag}, 16'h0001);
    wait_cyc(1);
    peek(4'd1, v); chk("R6 rising again", v, 16'd1);
  endtask

  task automatic t_capture();
    logic [15:0] v, c;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd4, 16'h0003);
    wr(4'd6, 16'h000B);
    peek(4'd6, v); chk("R11 ch2 ctl readback", v, 16'h000B);
    wr(4'd0, ctlw(2'd0, 2'd2, 1'b1));
    wait_cyc(10);
    cap_in[2:1] = 2'b11;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 async rising capture", v, 16'd10);
    chk("R7 ch1 flag", {15'b0, ch_flag[1]}, 16'h0001);
    wait_cyc(2);
    peek(4'd7, v); chk("R8 sync capture +2", v, 16'd12);
    chk("R8 ch2 flag", {15'b0, ch_flag[2]}, 16'h0001);
    // falling edge while rising-only: ignored
    wr(4'd4, 16'h0003);
    cap_in[1] = 1'b0;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 falling ignored (value)", v, 16'd10);
    chk("R7 falling ignored (flag)", {15'b0, ch_flag[1]}, 16'h0000);
    // falling-only
    wr(4'd4, 16'h0005);
    cap_in[1] = 1'b1;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 rising ignored", v, 16'd10);
    peek(4'd1, c);
    cap_in[1] = 1'b0;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 falling capture", v, c);
    // both edges, overrun
    wr(4'd4, 16'h0007);
    rd_ack(4'd5, v);
    peek(4'd1, c);
    cap_in[1] = 1'b1;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 both: rising", v, c);
    peek(4'd1, c);
    cap_in[1] = 1'b0;
    wait_cyc(1);
    peek(4'd5, v); chk("R7 both: falling", v, c);
    peek(4'd4, v); chk("R9 overrun sets cov", v, 16'h0037);
    rd_ack(4'd5, v);
    wr(4'd4, 16'h0007);
    peek(4'd1, c);
    cap_in[1] = 1'b1;
    wait_cyc(1);
    peek(4'd5, v); chk("R9 capture after ack", v, c);
    peek(4'd4, v); chk("R9 no cov after ack", v, 16'h0017);
  endtask

  task automatic t_compare();
    logic [15:0] v;
    wr(4'd0, ctlw(2'd0, 2'd0, 1'b0));
    wr(4'd4, 16'h0000);
    wr(4'd5, 16'd5);
    cap_in[1] = 1'b1;
    wr(4'd0, ctlw(2'd0, 2'd2, 1'b1));
    wait_cyc(5);
    chk("R10 before match", {15'b0, ch_flag[1]}, 16'h0000);
    wait_cyc(1);
    chk("R10 flag+out pins", {14'b0, ch_flag[1], ch_out[1]}, 16'h0003);
    peek(4'd4, v); chk("R10 ctl with latched input", v, 16'h00D0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; cap_in = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_cont();
    t_prescale();
    t_wrap();
    t_stop();
    t_up();
    t_updn();
    t_capture();
    t_compare();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule